// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits next to one serial channel and handles in-band pacing. It watches every byte the receiver delivers and, once it sees the programmed "stop" character (one or two bytes long), holds off the transmitter. It releases the transmitter when the programmed "go" character arrives, or on any byte at all when that option is on. An optional status flag reports a recognised stop character.

In the other direction, the block watches the receive FIFO fill count. When the count climbs past a selectable threshold, it asks the transmitter to send the stop character(s). When the count drains to the next lower threshold, it asks for the go character(s). If flow control is switched off after a stop was sent, the go character(s) still go out, so the far end is not left stalled. In single-character mode, matched control characters are flagged so that the receive FIFO can discard them.

Top module: `swflow_ctrl`

## Requirements
- R1: Four 8-bit character registers are selected by `cfg_sel`: 0 for go byte 1, 1 for go byte 2, 2 for stop byte 1 and 3 for stop byte 2. Each is written when `cfg_we` is high, and all four reset to 0x00. After reset, `tx_pause`, `inj_req`, `rx_drop` and `xoff_flag` are low.
- R2: In single mode (`two_byte`=0) with `fc_en`=1, a received byte equal to stop byte 1 raises `tx_pause`. A received byte equal to go byte 1 lowers it again. Each change shows in the cycle after the `rx_valid` cycle.
- R3: `rx_drop` is high for exactly the cycle after a byte that single mode recognised as a stop or go character. It stays low for ordinary data and for every byte in two-byte mode.
- R4: In two-byte mode, stop byte 1 followed by stop byte 2 pauses the transmitter. While paused, go byte 1 followed by go byte 2 resumes it.
- R5: If the second byte of a two-byte sequence does not match, the matcher goes back to looking for the first byte. The mismatching byte counts as data and is not compared as a first byte.
- R6: While `tx_busy` is high, a recognised stop does not raise `tx_pause`. `tx_pause` rises in the cycle after `tx_busy` falls.
- R7: `xoff_flag` sets on a recognised stop only when both `xoff_irq_en` and `modem_irq_en` are 1. It clears when transmission resumes.
- R8: With `any_resume`=1, any received byte while paused resumes transmission.
- R9: `trig_sel` codes 0, 1, 2 and 3 select thresholds of 8, 16, 56 and 60 entries. When `rx_count` exceeds the selected threshold and no stop has been sent, `inj_req` rises with the stop byte 1 value in the next cycle.
- R10: After a stop has been sent, `rx_count` falling to the next lower threshold starts the go sequence. The lower thresholds are 0, 8, 16 and 56 for codes 0 to 3.
- R11: A `tx_load` pulse while `inj_req` is high consumes the current byte. In two-byte mode the second character follows, and after the last byte `inj_req` drops.
- R12: If `fc_en` is cleared while a stop is outstanding, the go sequence is injected.
- R13: Injection requests are raised and served regardless of `tx_pause`.
- R14: While `fc_en`=0, received bytes are not matched, and `tx_pause` and `xoff_flag` are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Software flow control enable |
| two_byte | input | 1 | 1: two-byte control sequences |
| any_resume | input | 1 | 1: any byte resumes after a stop |
| xoff_irq_en | input | 1 | Stop-flag interrupt enable |
| modem_irq_en | input | 1 | Second enable gating the stop flag |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Character register select |
| cfg_data | input | 8 | Character register write data |
| trig_sel | input | 2 | Receive threshold select |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_load | input | 1 | Transmitter takes its next character |
| tx_pause | output | 1 | Hold off queued transmit data |
| inj_req | output | 1 | Control character waiting to be sent |
| inj_byte | output | 8 | Control character to send |
| rx_drop | output | 1 | Discard the byte just received |
| xoff_flag | output | 1 | Stop character recognised |

## Verification
Every output is a register. A received byte, a threshold crossing or a `tx_load` pulse therefore shows its effect in the cycle right after the edge that sampled it, and `rx_drop` lasts that one cycle only. The bench drives inputs on the falling edge and samples one falling edge later, so each check lands exactly one register stage after its stimulus. Delayed effects such as the pause held back by `tx_busy` are checked in every cycle of the wait and again in the single cycle after the release. The thresholds are swept over all four codes, probing one count either side of each boundary.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    SEL_GO1   = 2'd0,
    SEL_GO2   = 2'd1,
    SEL_STOP1 = 2'd2,
    SEL_STOP2 = 2'd3
  } char_sel_e;

  typedef struct packed {
    logic [CHAR_W-1:0] go1;
    logic [CHAR_W-1:0] go2;
    logic [CHAR_W-1:0] stop1;
    logic [CHAR_W-1:0] stop2;
  } fc_chars_t;
endpackage

// File: rtl/swfc_char_regs.sv
module swfc_char_regs
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CHAR_W-1:0] wdata,
  output fc_chars_t         chars
);
  localparam int NREG = 4;

  logic [CHAR_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (we && (sel == i[1:0]))
        regs[i] <= wdata;
    end
  end

  assign chars.go1   = regs[SEL_GO1];
  assign chars.go2   = regs[SEL_GO2];
  assign chars.stop1 = regs[SEL_STOP1];
  assign chars.stop2 = regs[SEL_STOP2];
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_en,
  input  logic              two_byte,
  input  logic              any_resume,
  input  logic              irq_en_a,
  input  logic              irq_en_b,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  input  logic              tx_busy,
  input  fc_chars_t         chars,
  output logic              tx_pause,
  output logic              rx_drop,
  output logic              xoff_flag
);
  logic paused;
  logic half;
  logic do_pause, do_resume, drop_now, half_nxt, paused_nxt;
  logic hit_go1;

  always_comb begin
    do_pause  = 1'b0;
    do_resume = 1'b0;
    drop_now  = 1'b0;
    half_nxt  = half;
    hit_go1   = (rx_byte == chars.go1);
    if (rx_valid && fc_en) begin
      if (!paused) begin
        if (!two_byte) begin
          if (rx_byte == chars.stop1) begin
            do_pause = 1'b1;
            drop_now = 1'b1;
          end
        end else if (!half) begin
          half_nxt = (rx_byte == chars.stop1);
        end else begin
          half_nxt = 1'b0;
          do_pause = (rx_byte == chars.stop2);
        end
      end else begin
        if (!two_byte) begin
          drop_now  = hit_go1;
          do_resume = hit_go1 || any_resume;
        end else if (any_resume) begin
          do_resume = 1'b1;
          half_nxt  = 1'b0;
        end else if (!half) begin
          half_nxt = hit_go1;
        end else begin
          half_nxt  = 1'b0;
          do_resume = (rx_byte == chars.go2);
        end
      end
    end
    if (!two_byte || !fc_en)
      half_nxt = 1'b0;
    paused_nxt = fc_en && (do_pause || (paused && !do_resume));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      paused    <= 1'b0;
      half      <= 1'b0;
      tx_pause  <= 1'b0;
      rx_drop   <= 1'b0;
      xoff_flag <= 1'b0;
    end else begin
      paused   <= paused_nxt;
      half     <= half_nxt;
      tx_pause <= paused_nxt && (tx_pause || !tx_busy);
      rx_drop  <= drop_now;
      if (!fc_en || do_resume)
        xoff_flag <= 1'b0;
      else if (do_pause && irq_en_a && irq_en_b)
        xoff_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/swfc_tx_inject.sv
module swfc_tx_inject
  import swfc_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 56,
  parameter int LVL3  = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_en,
  input  logic              two_byte,
  input  logic [1:0]        trig_sel,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_load,
  input  fc_chars_t         chars,
  output logic              inj_req,
  output logic [CHAR_W-1:0] inj_byte
);
  logic [CNT_W-1:0] hi_lvl, lo_lvl;
  logic sent_stop, second, kind_stop;
  logic want_stop, want_go;

  always_comb begin
    case (trig_sel)
      2'd0:    begin hi_lvl = CNT_W'(LVL0); lo_lvl = '0;           end
      2'd1:    begin hi_lvl = CNT_W'(LVL1); lo_lvl = CNT_W'(LVL0); end
      2'd2:    begin hi_lvl = CNT_W'(LVL2); lo_lvl = CNT_W'(LVL1); end
      default: begin hi_lvl = CNT_W'(LVL3); lo_lvl = CNT_W'(LVL2); end
    endcase
    want_stop = fc_en && !sent_stop && (rx_count > hi_lvl);
    want_go   = sent_stop && (!fc_en || (rx_count <= lo_lvl));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_req   <= 1'b0;
      inj_byte  <= '0;
      sent_stop <= 1'b0;
      second    <= 1'b0;
      kind_stop <= 1'b0;
    end else if (inj_req) begin
      if (tx_load) begin
        if (two_byte && !second) begin
          second   <= 1'b1;
          inj_byte <= kind_stop ? chars.stop2 : chars.go2;
        end else begin
          inj_req <= 1'b0;
          second  <= 1'b0;
        end
      end
    end else if (want_stop) begin
      inj_req   <= 1'b1;
      kind_stop <= 1'b1;
      sent_stop <= 1'b1;
      inj_byte  <= chars.stop1;
    end else if (want_go) begin
      inj_req   <= 1'b1;
      kind_stop <= 1'b0;
      sent_stop <= 1'b0;
      inj_byte  <= chars.go1;
    end
  end
endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
  import swfc_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 56,
  parameter int LVL3  = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fc_en,
  input  logic             two_byte,
  input  logic             any_resume,
  input  logic             xoff_irq_en,
  input  logic             modem_irq_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  input  logic [1:0]       trig_sel,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_busy,
  input  logic             tx_load,
  output logic             tx_pause,
  output logic             inj_req,
  output logic [7:0]       inj_byte,
  output logic             rx_drop,
  output logic             xoff_flag
);
  fc_chars_t chars;

  swfc_char_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_data),
    .chars (chars)
  );

  swfc_rx_match u_match (
    .clk        (clk),
    .rst        (rst),
    .fc_en      (fc_en),
    .two_byte   (two_byte),
    .any_resume (any_resume),
    .irq_en_a   (xoff_irq_en),
    .irq_en_b   (modem_irq_en),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .tx_busy    (tx_busy),
    .chars      (chars),
    .tx_pause   (tx_pause),
    .rx_drop    (rx_drop),
    .xoff_flag  (xoff_flag)
  );

  swfc_tx_inject #(
    .CNT_W (CNT_W),
    .LVL0  (LVL0),
    .LVL1  (LVL1),
    .LVL2  (LVL2),
    .LVL3  (LVL3)
  ) u_inject (
    .clk      (clk),
    .rst      (rst),
    .fc_en    (fc_en),
    .two_byte (two_byte),
    .trig_sel (trig_sel),
    .rx_count (rx_count),
    .tx_load  (tx_load),
    .chars    (chars),
    .inj_req  (inj_req),
    .inj_byte (inj_byte)
  );
endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             fc_en,
  input logic             two_byte,
  input logic             xoff_irq_en,
  input logic             modem_irq_en,
  input logic             rx_valid,
  input logic             tx_busy,
  input logic             tx_load,
  input logic             tx_pause,
  input logic             inj_req,
  input logic [7:0]       inj_byte,
  input logic             rx_drop,
  input logic             xoff_flag
);
  AST_PAUSE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_pause) |-> !$past(tx_busy)); // R6

  AST_DROP_SINGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    rx_drop |-> $past(rx_valid && fc_en && !two_byte)); // R3

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff_flag) |-> $past(xoff_irq_en && modem_irq_en)); // R7

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !fc_en |=> (!tx_pause && !xoff_flag)); // R14

  AST_INJ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inj_req && !tx_load) |=> (inj_req && $stable(inj_byte))); // R11

  AST_INJ_SINGLE_END: assert property (@(posedge clk) disable iff (rst)
    (inj_req && tx_load && !two_byte) |=> !inj_req); // R11
endmodule

bind swflow_ctrl swflow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fc_en        (fc_en),
  .two_byte     (two_byte),
  .xoff_irq_en  (xoff_irq_en),
  .modem_irq_en (modem_irq_en),
  .rx_valid     (rx_valid),
  .tx_busy      (tx_busy),
  .tx_load      (tx_load),
  .tx_pause     (tx_pause),
  .inj_req      (inj_req),
  .inj_byte     (inj_byte),
  .rx_drop      (rx_drop),
  .xoff_flag    (xoff_flag)
);

// File: tb/swflow_ctrl_bench.sv
module swflow_ctrl_bench;
  localparam int CNT_W = 7;
  localparam logic [7:0] GO1 = 8'h11, GO2 = 8'h12, ST1 = 8'h13, ST2 = 8'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fc_en = 0, two_byte = 0, any_resume = 0, xoff_irq_en = 0, modem_irq_en = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0, trig_sel = 0;
  logic [7:0] cfg_data = 0, rx_byte = 0;
  logic rx_valid = 0, tx_busy = 0, tx_load = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic tx_pause, inj_req, rx_drop, xoff_flag;
  logic [7:0] inj_byte;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swflow_ctrl u_swflow_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_data = d;
    step();
    cfg_we = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    step();
    rx_valid = 0;
  endtask

  task automatic load();
    tx_load = 1;
    step();
    tx_load = 0;
  endtask

  function automatic int hi_of(input int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
  endfunction

  function automatic int lo_of(input int s);
    return (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 56;
  endfunction

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    chk("R1 reset pause", tx_pause, 0);
    chk("R1 reset inj_req", inj_req, 0);
    chk("R1 reset drop", rx_drop, 0);
    chk("R1 reset flag", xoff_flag, 0);

    // R1: characters are zero after reset, seen through injection
    fc_en = 1; trig_sel = 0; rx_count = 9;
    step();
    chk("R1 stop char reset value", inj_byte, 0);
    chk("R9 inj on count 9 > 8", inj_req, 1);
    load();
    chk("R11 single-mode one byte", inj_req, 0);
    rx_count = 0;
    step();
    chk("R10 go inj at 0", inj_req, 1);
    chk("R1 go char reset value", inj_byte, 0);
    load();

    wr(2'd0, GO1); wr(2'd1, GO2); wr(2'd2, ST1); wr(2'd3, ST2);
    xoff_irq_en = 1; modem_irq_en = 1;

    // single mode matching
    rx(8'h41);
    chk("R2 data no pause", tx_pause, 0);
    chk("R3 data no drop", rx_drop, 0);
    rx(ST1);
    chk("R2 stop pauses", tx_pause, 1);
    chk("R3 stop dropped", rx_drop, 1);
    chk("R7 flag set", xoff_flag, 1);
    rx(ST1);
    chk("R2 still paused", tx_pause, 1);
    chk("R3 repeat stop not dropped", rx_drop, 0);
    rx(GO1);
    chk("R2 go resumes", tx_pause, 0);
    chk("R3 go dropped", rx_drop, 1);
    chk("R7 flag cleared", xoff_flag, 0);
    step();
    chk("R3 drop one cycle", rx_drop, 0);

    // R13 injection while paused
    rx(ST1);
    rx_count = 9;
    step();
    chk("R13 paused", tx_pause, 1);
    chk("R13 inj while paused", inj_req, 1);
    chk("R13 inj byte", inj_byte, ST1);
    load();
    chk("R13 served", inj_req, 0);
    rx(GO1);
    rx_count = 0;
    step();
    chk("R10 go byte", inj_byte, GO1);
    load();

    // R6 busy deferral
    tx_busy = 1;
    rx(ST1);
    chk("R6 held while busy", tx_pause, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 held while busy", tx_pause, 0);
    end
    tx_busy = 0;
    step();
    chk("R6 pause after idle", tx_pause, 1);
    rx(GO1);

    // R7 enable sweep
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        xoff_irq_en = a[0]; modem_irq_en = b[0];
        rx(ST1);
        chk("R7 flag gating", xoff_flag, a & b);
        rx(GO1);
        chk("R7 flag clear", xoff_flag, 0);
      end
    end
    xoff_irq_en = 1; modem_irq_en = 1;

    // R8 any resume
    any_resume = 1;
    rx(ST1);
    rx(8'h55);
    chk("R8 any byte resumes", tx_pause, 0);
    chk("R8 plain byte not dropped", rx_drop, 0);
    any_resume = 0;

    // two-byte mode
    two_byte = 1;
    rx(ST1);
    chk("R4 first byte only", tx_pause, 0);
    chk("R3 no drop two-byte", rx_drop, 0);
    rx(ST2);
    chk("R4 pair pauses", tx_pause, 1);
    rx(GO1);
    chk("R4 half go", tx_pause, 1);
    rx(GO2);
    chk("R4 pair resumes", tx_pause, 0);

    rx(ST1); rx(ST1); rx(ST2);
    chk("R5 mismatch not reexamined", tx_pause, 0);
    rx(ST1); rx(ST2);
    chk("R5 recovers", tx_pause, 1);
    rx(GO1); rx(8'h55); rx(GO2);
    chk("R5 go mismatch", tx_pause, 1);
    rx(GO1); rx(GO2);
    chk("R5 go pair", tx_pause, 0);

    // R14 disable
    rx(ST1); rx(ST2);
    chk("R14 paused first", xoff_flag, 1);
    fc_en = 0;
    step();
    chk("R14 pause cleared", tx_pause, 0);
    chk("R14 flag cleared", xoff_flag, 0);
    rx(ST1); rx(ST2);
    chk("R14 no match when off", tx_pause, 0);
    fc_en = 1;

    // R9 R10 R11 threshold sweep, two-byte injection
    for (int s = 0; s < 4; s++) begin
      trig_sel = s[1:0];
      rx_count = CNT_W'(hi_of(s));
      step(); step();
      chk("R9 at level no inj", inj_req, 0);
      rx_count = CNT_W'(hi_of(s) + 1);
      step();
      chk("R9 above level inj", inj_req, 1);
      chk("R9 stop byte 1", inj_byte, ST1);
      load();
      chk("R11 second pending", inj_req, 1);
      chk("R11 stop byte 2", inj_byte, ST2);
      load();
      chk("R11 done", inj_req, 0);
      rx_count = CNT_W'(lo_of(s) + 1);
      step(); step();
      chk("R10 above lower no inj", inj_req, 0);
      rx_count = CNT_W'(lo_of(s));
      step();
      chk("R10 go inj", inj_req, 1);
      chk("R10 go byte 1", inj_byte, GO1);
      load();
      chk("R11 go byte 2", inj_byte, GO2);
      load();
      chk("R11 go done", inj_req, 0);
    end

    // R12 disable with stop outstanding
    trig_sel = 2'd3; rx_count = 61;
    step();
    load(); load();
    chk("R12 stop done", inj_req, 0);
    fc_en = 0;
    step();
    chk("R12 go on disable", inj_req, 1);
    chk("R12 go byte", inj_byte, GO1);
    load();
    load();
    chk("R12 go finished", inj_req, 0);
    rx_count = 0; fc_en = 1;
    step(); step();
    chk("R12 no second go", inj_req, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule